// File: doc/BRIEF.md
# Buddy Block Allocator

This block hands out and takes back address ranges of a data memory of 2^MEM_LOG2 bytes, in blocks whose sizes are powers of two between 2^MIN_LOG2 and the whole memory. An allocate request carries a byte count. The block answers with the base address of a block that is just large enough. When no block of the needed size is free, it splits a larger free block in halves as many times as needed. A release request carries a base address. The block looks up the size that it recorded when it granted that address. It then returns the block to the free pool and joins it with its buddy, which is the neighbour whose address differs only in the bit equal to the block size. This joining repeats at each larger size as long as the buddy is free.

Requests and responses are both valid/ready streams. The block works on one request at a time. `req_ready` is high only when the block is idle, with no walk in progress and no response waiting. A response stays on `rsp_valid`, `rsp_addr` and `rsp_err` until `rsp_ready` accepts it. While the response is held, no new request is taken, so back-pressure on the response side stalls the request side. The block manages addresses only. It neither stores nor touches the data.

Top module: `buddy_alloc`

## Requirements
- R1: After reset, `req_ready` is high, `rsp_valid` is low, and the whole memory is one free block: an allocation of 2^MEM_LOG2 bytes succeeds at address 0.
- R2: An allocation of m bytes is served with a block of 2^p bytes, where p is the smallest value with 2^p ≥ m, raised to MIN_LOG2 if smaller. The address granted is a multiple of that block size.
- R3: Allocation uses the smallest size class at or above the needed one that has a free block, and takes the lowest-addressed free block of that class. Each split keeps the lower half for further use and leaves the upper half free.
- R4: An allocation of 0 bytes, or of more than 2^MEM_LOG2 bytes, responds with `rsp_err`=1 one cycle after acceptance and leaves the free pool unchanged.
- R5: When no free block of a sufficient size exists, the allocation responds with `rsp_err`=1 and the free pool is unchanged.
- R6: A release frees the block recorded at that address. If the buddy at the same size (address with bit p flipped) is free, the two merge into one block of twice the size, and the merge repeats upward.
- R7: A release whose address has nonzero bits below MIN_LOG2, or that is not the base of a currently allocated block (including a second release of the same block), responds with `rsp_err`=1 and changes nothing.
- R8: While a response is pending, `req_ready` is low. A response with `rsp_ready` low keeps `rsp_valid`, `rsp_addr` and `rsp_err` unchanged on the next cycle.
- R9: A successful release responds with `rsp_err`=0 and `rsp_addr` equal to the released address. The value of `rsp_addr` carries no meaning when `rsp_err`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_free | input | 1 | 1 = release `req_addr`, 0 = allocate `req_bytes` |
| req_bytes | input | MEM_LOG2+1 | Byte count of an allocation |
| req_addr | input | MEM_LOG2 | Base address of a release |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | MEM_LOG2 | Granted or released base address |
| rsp_err | output | 1 | Request failed |

## Verification
The bench builds the block with MEM_LOG2=7 and MIN_LOG2=4. This gives a 128-byte memory with eight 16-byte minimum blocks and four size classes. With these values the bench can fill the memory completely, force out-of-memory failures, and drive a release chain that merges all the way back to a single block within a few dozen requests. It also covers rounding from odd byte counts, split order within a size class, double and misaligned releases, and a response held under back-pressure.

// File: rtl/buddy_pkg.sv
package buddy_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SPLIT,
    ST_MERGE,
    ST_RESP
  } buddy_state_e;
endpackage

// File: rtl/buddy_size_class.sv
// Maps a byte count to a size class index (0 = 2^MIN_LOG2 bytes).
module buddy_size_class #(
  parameter int MEM_LOG2 = 10,
  parameter int MIN_LOG2 = 4,
  parameter int LVL_W    = 3
) (
  input  logic [MEM_LOG2:0] bytes,
  output logic [LVL_W-1:0]  lvl,
  output logic              err
);
  localparam int P_W = $clog2(MEM_LOG2 + 2);
  localparam logic [MEM_LOG2:0] BYTES_MAX = {1'b1, {MEM_LOG2{1'b0}}};

  logic [MEM_LOG2:0] less_one;
  logic [P_W-1:0]    pow;

  always_comb begin
    less_one = bytes - 1'b1;
    pow = '0;
    for (int i = 0; i <= MEM_LOG2; i++) begin
      if (less_one[i]) pow = P_W'(i + 1);
    end
    err = (bytes == '0) || (bytes > BYTES_MAX);
    if (pow <= P_W'(MIN_LOG2)) lvl = '0;
    else lvl = LVL_W'(pow - P_W'(MIN_LOG2));
  end
endmodule

// File: rtl/buddy_first_set.sv
// Lowest set bit of a vector.
module buddy_first_set #(
  parameter int W     = 64,
  parameter int IDX_W = 6
) (
  input  logic [W-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/buddy_level_search.sv
// Smallest size class at or above the wanted one holding a free block.
module buddy_level_search #(
  parameter int LEVELS = 7,
  parameter int NBLK   = 64,
  parameter int IDX_W  = 6,
  parameter int LVL_W  = 3
) (
  input  logic [LEVELS-1:0][NBLK-1:0] free_map,
  input  logic [LVL_W-1:0]            want_lvl,
  output logic                        hit,
  output logic [LVL_W-1:0]            hit_lvl,
  output logic [IDX_W-1:0]            hit_idx
);
  logic [LEVELS-1:0] lvl_any;
  logic [IDX_W-1:0]  lvl_idx [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    buddy_first_set #(.W(NBLK), .IDX_W(IDX_W)) u_fs (
      .vec (free_map[l]),
      .any (lvl_any[l]),
      .idx (lvl_idx[l])
    );
  end

  always_comb begin
    hit     = 1'b0;
    hit_lvl = '0;
    hit_idx = '0;
    for (int l = LEVELS - 1; l >= 0; l--) begin
      if (LVL_W'(l) >= want_lvl && lvl_any[l]) begin
        hit     = 1'b1;
        hit_lvl = LVL_W'(l);
        hit_idx = lvl_idx[l];
      end
    end
  end
endmodule

// File: rtl/buddy_alloc.sv
module buddy_alloc #(
  parameter int MEM_LOG2 = 10,
  parameter int MIN_LOG2 = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_free,
  input  logic [MEM_LOG2:0]   req_bytes,
  input  logic [MEM_LOG2-1:0] req_addr,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [MEM_LOG2-1:0] rsp_addr,
  output logic                rsp_err
);
  import buddy_pkg::*;

  localparam int TOP    = MEM_LOG2 - MIN_LOG2;
  localparam int LEVELS = TOP + 1;
  localparam int NBLK   = 1 << TOP;
  localparam int IDX_W  = TOP;
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(TOP);

  buddy_state_e state;
  logic [LEVELS-1:0][NBLK-1:0] free_map;
  logic [NBLK-1:0]  alloc_map;
  logic [LVL_W-1:0] ord_tab [NBLK];
  logic [LVL_W-1:0] cur_lvl, tgt_lvl;
  logic [IDX_W-1:0] cur_idx;
  logic [MEM_LOG2-1:0] rsp_addr_q;
  logic rsp_err_q;

  logic [LVL_W-1:0] sz_lvl, hit_lvl;
  logic             sz_err, hit;
  logic [IDX_W-1:0] hit_idx, req_slot, grant_slot;
  logic             req_misal, rel_ok, accept;

  buddy_size_class #(.MEM_LOG2(MEM_LOG2), .MIN_LOG2(MIN_LOG2), .LVL_W(LVL_W)) u_size (
    .bytes (req_bytes),
    .lvl   (sz_lvl),
    .err   (sz_err)
  );

  buddy_level_search #(.LEVELS(LEVELS), .NBLK(NBLK), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_search (
    .free_map (free_map),
    .want_lvl (sz_lvl),
    .hit      (hit),
    .hit_lvl  (hit_lvl),
    .hit_idx  (hit_idx)
  );

  always_comb begin
    req_slot   = req_addr[MEM_LOG2-1:MIN_LOG2];
    req_misal  = |req_addr[MIN_LOG2-1:0];
    rel_ok     = !req_misal && alloc_map[req_slot];
    grant_slot = cur_idx << cur_lvl;
    accept     = req_valid && req_ready;
  end

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_addr  = rsp_addr_q;
  assign rsp_err   = rsp_err_q;

  // Order recorded at grant time; read only where alloc_map marks a head.
  always_ff @(posedge clk) begin
    if (state == ST_SPLIT && cur_lvl == tgt_lvl) ord_tab[grant_slot] <= tgt_lvl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      free_map    <= '0;
      free_map[TOP][0] <= 1'b1;
      alloc_map   <= '0;
      cur_lvl     <= '0;
      tgt_lvl     <= '0;
      cur_idx     <= '0;
      rsp_addr_q  <= '0;
      rsp_err_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          rsp_addr_q <= '0;
          rsp_err_q  <= 1'b0;
          if (!req_free) begin
            if (sz_err || !hit) begin
              rsp_err_q <= 1'b1;
              state     <= ST_RESP;
            end else begin
              free_map[hit_lvl][hit_idx] <= 1'b0;
              cur_lvl <= hit_lvl;
              cur_idx <= hit_idx;
              tgt_lvl <= sz_lvl;
              state   <= ST_SPLIT;
            end
          end else if (!rel_ok) begin
            rsp_err_q <= 1'b1;
            state     <= ST_RESP;
          end else begin
            alloc_map[req_slot] <= 1'b0;
            cur_lvl    <= ord_tab[req_slot];
            cur_idx    <= req_slot >> ord_tab[req_slot];
            rsp_addr_q <= req_addr;
            state      <= ST_MERGE;
          end
        end
        ST_SPLIT: begin
          if (cur_lvl == tgt_lvl) begin
            alloc_map[grant_slot] <= 1'b1;
            rsp_addr_q <= {grant_slot, {MIN_LOG2{1'b0}}};
            state      <= ST_RESP;
          end else begin
            free_map[cur_lvl - LVL_W'(1)][(cur_idx << 1) | IDX_W'(1)] <= 1'b1;
            cur_idx <= cur_idx << 1;
            cur_lvl <= cur_lvl - LVL_W'(1);
          end
        end
        ST_MERGE: begin
          if (cur_lvl < TOP_LVL && free_map[cur_lvl][cur_idx ^ IDX_W'(1)]) begin
            free_map[cur_lvl][cur_idx ^ IDX_W'(1)] <= 1'b0;
            cur_idx <= cur_idx >> 1;
            cur_lvl <= cur_lvl + LVL_W'(1);
          end else begin
            free_map[cur_lvl][cur_idx] <= 1'b1;
            state <= ST_RESP;
          end
        end
        default: if (rsp_ready) state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/buddy_alloc_chk.sv
module buddy_alloc_chk #(
  parameter int MEM_LOG2 = 10,
  parameter int MIN_LOG2 = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_free,
  input logic [MEM_LOG2:0]   req_bytes,
  input logic [MEM_LOG2-1:0] req_addr,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [MEM_LOG2-1:0] rsp_addr,
  input logic                rsp_err
);
  localparam logic [MEM_LOG2:0] BYTES_MAX = {1'b1, {MEM_LOG2{1'b0}}};

  assert_busy_while_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_rsp_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_err));

  assert_zero_bytes_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_free && req_bytes == '0 |=> rsp_valid && rsp_err);

  assert_oversize_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_free && req_bytes > BYTES_MAX |=> rsp_valid && rsp_err);

  assert_misaligned_release_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_free && (|req_addr[MIN_LOG2-1:0]) |=> rsp_valid && rsp_err);

  assert_grant_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err |-> rsp_addr[MIN_LOG2-1:0] == '0);
endmodule

bind buddy_alloc buddy_alloc_chk #(.MEM_LOG2(MEM_LOG2), .MIN_LOG2(MIN_LOG2)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_free  (req_free),
  .req_bytes (req_bytes),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_addr  (rsp_addr),
  .rsp_err   (rsp_err)
);

// File: tb/buddy_alloc_tb_top.sv
`timescale 1ns/1ps
module buddy_alloc_tb_top;
  localparam int N   = 7;
  localparam int MIN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_free = 1'b0;
  logic [N:0] req_bytes = '0;
  logic [N-1:0] req_addr = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [N-1:0] rsp_addr;
  logic rsp_err;

  always #2.5 clk = ~clk;

  buddy_alloc #(.MEM_LOG2(N), .MIN_LOG2(MIN)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_free(req_free),
    .req_bytes(req_bytes), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_err(rsp_err)
  );

  typedef struct {
    logic         err;
    logic [N-1:0] addr;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: queue the expected response, then hand the request over.
  task automatic send(input bit fr, input int bytes, input int addr,
                      input bit e_err, input int e_addr, input string tag);
    exp_t e;
    e.err = e_err; e.addr = N'(e_addr); e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1;
    req_free  = fr;
    req_bytes = (N+1)'(bytes);
    req_addr  = N'(addr);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compare every accepted response with the head of the queue.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_err == e.err, {e.tag, " err"}, int'(rsp_err), int'(e.err));
        if (!e.err) check(rsp_addr == e.addr, {e.tag, " addr"}, int'(rsp_addr), int'(e.addr));
      end
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);

    send(0, 128, 0, 0, 0,  "R1 whole memory");
    send(0, 16,  0, 1, 0,  "R5 full memory");
    send(1, 0,   0, 0, 0,  "R9 release whole");
    send(0, 0,   0, 1, 0,  "R4 zero bytes");
    send(0, 129, 0, 1, 0,  "R4 oversize");
    send(0, 17,  0, 0, 0,  "R2 17 bytes rounds to 32");
    send(0, 16,  0, 0, 32, "R3 split keeps upper half free");
    send(0, 1,   0, 0, 48, "R2 one byte gets min block");
    send(0, 64,  0, 0, 64, "R3 lowest free 64");
    send(0, 1,   0, 1, 0,  "R5 no block left");
    send(1, 0,   40, 1, 0, "R7 misaligned release");
    send(1, 0,   16, 1, 0, "R7 release inside a block");
    send(1, 0,   32, 0, 32, "R9 release 32");
    send(1, 0,   32, 1, 0, "R7 double release");
    send(0, 16,  0, 0, 32, "R6 no merge while buddy busy");
    send(1, 0,   32, 0, 32, "R6 release again");
    send(1, 0,   48, 0, 48, "R6 release buddy 48");
    send(0, 32,  0, 0, 32, "R6 merged 32 at 32");
    send(1, 0,   32, 0, 32, "R6 release 32 block");
    send(1, 0,   0,  0, 0,  "R6 release 0 merges to 64");
    send(0, 128, 0, 1, 0,  "R5 128 blocked by 64 held");
    send(0, 64,  0, 0, 0,  "R6 merged 64 at 0");
    send(1, 0,   0,  0, 0,  "R6 release 64 at 0");
    send(1, 0,   64, 0, 64, "R6 release 64 at 64");
    send(0, 128, 0, 0, 0,  "R6 full merge");
    drain();

    // Back-pressure on the response side.
    @(negedge clk);
    rsp_ready = 1'b0;
    send(1, 0, 0, 0, 0, "R8 held release");
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b1, "R8 response held", int'(rsp_valid), 1);
    check(req_ready == 1'b0, "R8 request side stalled", int'(req_ready), 0);
    check(rsp_addr == '0, "R8 address stable", int'(rsp_addr), 0);
    rsp_ready = 1'b1;
    drain();
    check(req_ready == 1'b1, "R8 ready after response taken", int'(req_ready), 1);

    send(0, 48, 0, 0, 0, "R2 48 bytes rounds to 64");
    send(0, 33, 0, 0, 64, "R2 33 bytes rounds to 64");
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule